// File: doc/BRIEF.md
# Runtime-Programmable Video Timing Generator

This block produces the raster timing for a video output: horizontal and vertical sync, a border flag, an active-video flag, the pixel column and line index inside the visible area, and a text-cell column index. It runs one pixel per clock. Horizontal timing is counted in pixel clocks and vertical timing in lines. Each line is made of a front porch, the sync pulse, a back porch and the visible pixels, in that order. Each frame is made of the sync lines, an upper porch, the visible lines and a lower porch, in that order.

All timing values come in on configuration ports. The block copies them into a private shadow set once per frame, and the running frame only ever uses the shadow set. Software can therefore rewrite the configuration at any time while video runs, and the new mode starts cleanly with the next frame. A band of configurable width along each edge of the visible area is reported as border, and only the area inside that band is reported as active. The active area is split into character cells of a programmable pixel width, and their column index wraps after a programmable number of characters per line.

Configuration constraints: pixels per character is at least 1, characters per line is at least 1, twice the horizontal border is at most the visible width, and twice the vertical border is at most the visible line count.

Top module: `vidTimingGen`

## Requirements
- R1: While rstN is low, hsyncO and vsyncO are 1, borderO and activeO are 0, and pixX, lineY and charCol are 0.
- R2: A line lasts front + sync + back + visible clocks. Its pixel h (0-based) is in hsync when front <= h < front + sync, and it is visible when h >= front + sync + back. With the invert bit at 0, hsyncO is 0 during hsync and 1 elsewhere.
- R3: A frame lasts vsync + upper + lines + lower lines. Line v is in vsync when v < vsync width for the whole line, and it is visible when vsync + upper <= v < vsync + upper + lines. With the invert bit at 0, vsyncO is 0 during vsync and 1 elsewhere.
- R4: With cfgSyncInvert at 1, both sync outputs become high-active: 1 inside their sync window and 0 outside it.
- R5: In a visible pixel of a visible line, activeO is 1 when the pixel lies more than hBorder pixels from either horizontal edge and more than vBorder lines from either vertical edge. Otherwise borderO is 1. Both flags are 0 outside the visible area, and they are never 1 together.
- R6: pixX is the pixel offset from the first visible pixel of the line, and it is 0 outside the visible pixels. lineY is the line offset from the first visible line, and it is 0 on non-visible lines.
- R7: charCol is 0 outside the active area. Inside the active area it equals floor((pixX - hBorder) / pixPerChar) modulo charsPerLine, so it wraps to 0 after charsPerLine - 1.
- R8: In the first clock after reset is released, the configuration is captured and all outputs keep their idle values. After the second rising edge, the outputs describe frame position (line 0, pixel 0), and from then on they advance one pixel per clock.
- R9: The configuration ports are sampled only in the first clock after reset and in the last clock of each frame. A change at any other time has no effect on the frame in progress, and it takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgHFront | input | TW | Clocks before hsync |
| cfgHSync | input | TW | Hsync width in clocks |
| cfgHBack | input | TW | Clocks between hsync and the visible pixels |
| cfgHVis | input | TW | Visible pixels per line |
| cfgHBorder | input | TW | Border width at the left and at the right |
| cfgVSync | input | TW | Vsync width in lines |
| cfgVUpper | input | TW | Non-visible lines after vsync |
| cfgVLines | input | TW | Visible lines per frame |
| cfgVLower | input | TW | Non-visible lines after the visible lines |
| cfgVBorder | input | TW | Border height at the top and at the bottom |
| cfgPixPerChar | input | CW | Pixel width of a character cell |
| cfgCharsPerLine | input | TW | Character columns before charCol wraps |
| cfgSyncInvert | input | 1 | 0: syncs active low, 1: syncs active high |
| hsyncO | output | 1 | Horizontal sync |
| vsyncO | output | 1 | Vertical sync |
| borderO | output | 1 | Pixel lies in the border band |
| activeO | output | 1 | Pixel lies in the active area |
| pixX | output | TW | Column inside the visible width |
| lineY | output | TW | Row inside the visible lines |
| charCol | output | TW | Character column inside the active area |

## Verification
Every cycle, the assertions check that the counters stay inside the shadowed line and frame lengths, that hsync never overlaps visible pixels, that the shadow set changes only at a frame wrap, that border and active are never raised together, and that a nonzero character column appears only in the active area. The exact placement of every sync edge, the border band and the coordinates depend on the programmed numbers, so only the bench's scenarios can show them. These scenarios cover several modes, an inverted polarity, a zero-width border, character-column wraparound and a mid-frame configuration change that must not disturb the running frame.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int unsigned TW = 12;      // timing field width
  localparam int unsigned CW = 4;       // pixels-per-character field width
  localparam int unsigned SW = TW + 2;  // width of summed positions

  typedef struct packed {
    logic [TW-1:0] hFront;
    logic [TW-1:0] hSync;
    logic [TW-1:0] hBack;
    logic [TW-1:0] hVis;
    logic [TW-1:0] hBord;
    logic [TW-1:0] vSync;
    logic [TW-1:0] vUpper;
    logic [TW-1:0] vLines;
    logic [TW-1:0] vLower;
    logic [TW-1:0] vBord;
    logic [CW-1:0] ppc;
    logic [TW-1:0] cpl;
    logic          syncInv;
  } vtgTiming_t;

  typedef struct packed {
    logic          hSync;
    logic          vSync;
    logic          hVis;
    logic          vVis;
    logic          hAct;
    logic          vAct;
    logic          hVisFirst;
    logic          hActFirst;
    logic          lineStart;
    logic          vVisFirst;
    logic          syncInv;
    logic [CW-1:0] ppc;
    logic [TW-1:0] cpl;
  } vtgStrobe_t;
endpackage

// File: rtl/vtgCtrl.sv
module vtgCtrl
  import vtg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  vtgTiming_t cfgIn,
  output vtgStrobe_t info
);
  vtgTiming_t    sh;
  logic          primed;
  logic [SW-1:0] hCnt, vCnt;
  logic [SW-1:0] hSyncBeg, hSyncEnd, hVisBeg, hEnd, hLast, hActBeg, hActEnd;
  logic [SW-1:0] vSyncEnd, vVisBeg, vVisEnd, vLast, vActBeg, vActEnd;
  logic          frameWrap;

  always_comb begin
    hSyncBeg = SW'(sh.hFront);
    hSyncEnd = hSyncBeg + SW'(sh.hSync);
    hVisBeg  = hSyncEnd + SW'(sh.hBack);
    hEnd     = hVisBeg + SW'(sh.hVis);
    hLast    = hEnd - SW'(1);
    hActBeg  = hVisBeg + SW'(sh.hBord);
    hActEnd  = hEnd - SW'(sh.hBord);
    vSyncEnd = SW'(sh.vSync);
    vVisBeg  = vSyncEnd + SW'(sh.vUpper);
    vVisEnd  = vVisBeg + SW'(sh.vLines);
    vLast    = vVisEnd + SW'(sh.vLower) - SW'(1);
    vActBeg  = vVisBeg + SW'(sh.vBord);
    vActEnd  = vVisEnd - SW'(sh.vBord);
  end

  assign frameWrap = primed && (hCnt == hLast) && (vCnt == vLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed <= 1'b0;
      hCnt   <= '0;
      vCnt   <= '0;
      sh     <= '0;
    end else if (!primed) begin
      primed <= 1'b1;
      sh     <= cfgIn;
    end else if (hCnt == hLast) begin
      hCnt <= '0;
      if (vCnt == vLast) begin
        vCnt <= '0;
        sh   <= cfgIn;
      end else begin
        vCnt <= vCnt + SW'(1);
      end
    end else begin
      hCnt <= hCnt + SW'(1);
    end
  end

  always_comb begin
    info = '0;
    if (primed) begin
      info.hSync     = (hCnt >= hSyncBeg) && (hCnt < hSyncEnd);
      info.vSync     = (vCnt < vSyncEnd);
      info.hVis      = (hCnt >= hVisBeg) && (hCnt < hEnd);
      info.vVis      = (vCnt >= vVisBeg) && (vCnt < vVisEnd);
      info.hAct      = (hCnt >= hActBeg) && (hCnt < hActEnd);
      info.vAct      = (vCnt >= vActBeg) && (vCnt < vActEnd);
      info.hVisFirst = (hCnt == hVisBeg);
      info.hActFirst = (hCnt == hActBeg);
      info.lineStart = (hCnt == '0);
      info.vVisFirst = (vCnt == vVisBeg);
      info.syncInv   = sh.syncInv;
      info.ppc       = sh.ppc;
      info.cpl       = sh.cpl;
    end
  end

  // R2
  h_in_line_chk: assert property (@(posedge clk) disable iff (!rstN) hCnt <= hLast);
  // R2
  hsync_not_visible_chk: assert property (@(posedge clk) disable iff (!rstN) info.hSync |-> !info.hVis);
  // R3
  v_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN) vCnt <= vLast);
  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !frameWrap) |=> $stable(sh));
endmodule

// File: rtl/vtgDatapath.sv
module vtgDatapath
  import vtg_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  vtgStrobe_t    info,
  output logic          hsyncO,
  output logic          vsyncO,
  output logic          borderO,
  output logic          activeO,
  output logic [TW-1:0] pixX,
  output logic [TW-1:0] lineY,
  output logic [TW-1:0] charCol
);
  logic          act;
  logic [CW-1:0] subPix;

  assign act = info.hAct && info.vAct && info.hVis && info.vVis;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsyncO  <= 1'b1;
      vsyncO  <= 1'b1;
      borderO <= 1'b0;
      activeO <= 1'b0;
      pixX    <= '0;
      lineY   <= '0;
      charCol <= '0;
      subPix  <= '0;
    end else begin
      hsyncO  <= info.syncInv ? info.hSync : ~info.hSync;
      vsyncO  <= info.syncInv ? info.vSync : ~info.vSync;
      activeO <= act;
      borderO <= info.hVis && info.vVis && !act;

      if (info.hVisFirst && info.hVis) pixX <= '0;
      else if (info.hVis)              pixX <= pixX + TW'(1);
      else                             pixX <= '0;

      if (info.lineStart) begin
        if (info.vVis && info.vVisFirst) lineY <= '0;
        else if (info.vVis)              lineY <= lineY + TW'(1);
        else                             lineY <= '0;
      end

      if (!act || info.hActFirst) begin
        charCol <= '0;
        subPix  <= '0;
      end else if (subPix == info.ppc - CW'(1)) begin
        subPix  <= '0;
        charCol <= (charCol == info.cpl - TW'(1)) ? '0 : charCol + TW'(1);
      end else begin
        subPix <= subPix + CW'(1);
      end
    end
  end

  // R5
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN) !(borderO && activeO));
  // R7
  col_only_active_chk: assert property (@(posedge clk) disable iff (!rstN) (charCol != '0) |-> activeO);
endmodule

// File: rtl/vidTimingGen.sv
module vidTimingGen
  import vtg_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [TW-1:0] cfgHFront,
  input  logic [TW-1:0] cfgHSync,
  input  logic [TW-1:0] cfgHBack,
  input  logic [TW-1:0] cfgHVis,
  input  logic [TW-1:0] cfgHBorder,
  input  logic [TW-1:0] cfgVSync,
  input  logic [TW-1:0] cfgVUpper,
  input  logic [TW-1:0] cfgVLines,
  input  logic [TW-1:0] cfgVLower,
  input  logic [TW-1:0] cfgVBorder,
  input  logic [CW-1:0] cfgPixPerChar,
  input  logic [TW-1:0] cfgCharsPerLine,
  input  logic          cfgSyncInvert,
  output logic          hsyncO,
  output logic          vsyncO,
  output logic          borderO,
  output logic          activeO,
  output logic [TW-1:0] pixX,
  output logic [TW-1:0] lineY,
  output logic [TW-1:0] charCol
);
  vtgTiming_t cfgBus;
  vtgStrobe_t strobes;

  always_comb begin
    cfgBus.hFront  = cfgHFront;
    cfgBus.hSync   = cfgHSync;
    cfgBus.hBack   = cfgHBack;
    cfgBus.hVis    = cfgHVis;
    cfgBus.hBord   = cfgHBorder;
    cfgBus.vSync   = cfgVSync;
    cfgBus.vUpper  = cfgVUpper;
    cfgBus.vLines  = cfgVLines;
    cfgBus.vLower  = cfgVLower;
    cfgBus.vBord   = cfgVBorder;
    cfgBus.ppc     = cfgPixPerChar;
    cfgBus.cpl     = cfgCharsPerLine;
    cfgBus.syncInv = cfgSyncInvert;
  end

  vtgCtrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .cfgIn (cfgBus),
    .info  (strobes)
  );

  vtgDatapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .info    (strobes),
    .hsyncO  (hsyncO),
    .vsyncO  (vsyncO),
    .borderO (borderO),
    .activeO (activeO),
    .pixX    (pixX),
    .lineY   (lineY),
    .charCol (charCol)
  );
endmodule

// File: tb/vidTimingGen_bench.sv
module vidTimingGen_bench;
  import vtg_pkg::*;
  localparam int ClkPeriod = 10;

  typedef struct {
    int hf, hs, hb, hv, hbd, vs, vu, vl, vlo, vbd, ppc, cpl;
    bit inv;
  } mode_t;

  typedef struct {
    bit hs, vs, bd, ac, inv, first;
    int x, y, col, fr;
  } exp_t;

  logic clk = 1'b0, rstN = 1'b0;
  logic [TW-1:0] cHF, cHS, cHB, cHV, cHBd, cVS, cVU, cVL, cVLo, cVBd, cCpl;
  logic [CW-1:0] cPpc;
  logic cInv;
  logic hsyncO, vsyncO, borderO, activeO;
  logic [TW-1:0] pixX, lineY, charCol;

  int total = 0, bad = 0;
  bit monOn = 0;
  exp_t q[$];

  always #(ClkPeriod/2) clk = ~clk;

  vidTimingGen u_vidTimingGen (
    .clk(clk), .rstN(rstN),
    .cfgHFront(cHF), .cfgHSync(cHS), .cfgHBack(cHB), .cfgHVis(cHV), .cfgHBorder(cHBd),
    .cfgVSync(cVS), .cfgVUpper(cVU), .cfgVLines(cVL), .cfgVLower(cVLo), .cfgVBorder(cVBd),
    .cfgPixPerChar(cPpc), .cfgCharsPerLine(cCpl), .cfgSyncInvert(cInv),
    .hsyncO(hsyncO), .vsyncO(vsyncO), .borderO(borderO), .activeO(activeO),
    .pixX(pixX), .lineY(lineY), .charCol(charCol)
  );

  task automatic chk(string tag, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic applyMode(mode_t m);
    cHF = TW'(m.hf); cHS = TW'(m.hs); cHB = TW'(m.hb); cHV = TW'(m.hv); cHBd = TW'(m.hbd);
    cVS = TW'(m.vs); cVU = TW'(m.vu); cVL = TW'(m.vl); cVLo = TW'(m.vlo); cVBd = TW'(m.vbd);
    cPpc = CW'(m.ppc); cCpl = TW'(m.cpl); cInv = m.inv;
  endtask

  function automatic int frameLen(mode_t m);
    return (m.hf + m.hs + m.hb + m.hv) * (m.vs + m.vu + m.vl + m.vlo);
  endfunction

  // Driver: expected outputs for one whole frame, computed from R2..R7
  task automatic pushFrame(mode_t m, int fr);
    int hTot = m.hf + m.hs + m.hb + m.hv;
    int vTot = m.vs + m.vu + m.vl + m.vlo;
    int hvb  = m.hf + m.hs + m.hb;
    int vvb  = m.vs + m.vu;
    for (int v = 0; v < vTot; v++) begin
      for (int h = 0; h < hTot; h++) begin
        exp_t e;
        bit inH, inV, hv, vv, ha, va;
        inH = (h >= m.hf) && (h < m.hf + m.hs);
        inV = (v < m.vs);
        hv  = (h >= hvb);
        vv  = (v >= vvb) && (v < vvb + m.vl);
        e.x = hv ? h - hvb : 0;
        e.y = vv ? v - vvb : 0;
        ha  = hv && (e.x >= m.hbd) && (e.x < m.hv - m.hbd);
        va  = vv && (e.y >= m.vbd) && (e.y < m.vl - m.vbd);
        e.ac  = ha && va;
        e.bd  = hv && vv && !e.ac;
        e.col = e.ac ? ((e.x - m.hbd) / m.ppc) % m.cpl : 0;
        e.hs  = m.inv ? inH : !inH;
        e.vs  = m.inv ? inV : !inV;
        e.inv = m.inv;
        e.fr  = fr;
        e.first = (v == 0) && (h == 0);
        q.push_back(e);
      end
    end
  endtask

  // Monitor: pops one expected item per clock and compares
  always @(negedge clk) begin
    if (monOn && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.inv ? "R4 hsync" : "R2 hsync", int'(hsyncO), int'(e.hs));
      chk(e.inv ? "R4 vsync" : "R3 vsync", int'(vsyncO), int'(e.vs));
      chk("R5 border", int'(borderO), int'(e.bd));
      chk("R5 active", int'(activeO), int'(e.ac));
      chk("R6 pixX", int'(pixX), e.x);
      chk("R6 lineY", int'(lineY), e.y);
      chk("R7 charCol", int'(charCol), e.col);
      if (e.first && e.fr == 0)
        chk("R8 first pixel position", int'(pixX) + int'(lineY) + int'(borderO) + int'(activeO),
            e.x + e.y + int'(e.bd) + int'(e.ac));
      if (e.fr == 3)  // R9: mid-frame junk on the ports must not alter this frame
        chk("R9 frame unaffected", {hsyncO, vsyncO, borderO, activeO} == {e.hs, e.vs, e.bd, e.ac} ? 1 : 0, 1);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R8 watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mode_t mA, mB, mC, mD, mE;
    mA = '{hf:2, hs:3, hb:2, hv:12, hbd:2, vs:2, vu:1, vl:6, vlo:2, vbd:1, ppc:3, cpl:3, inv:0};
    mB = '{hf:1, hs:2, hb:3, hv:10, hbd:0, vs:1, vu:2, vl:5, vlo:1, vbd:0, ppc:2, cpl:5, inv:1};
    mC = '{hf:3, hs:1, hb:1, hv:12, hbd:2, vs:2, vu:1, vl:4, vlo:2, vbd:1, ppc:2, cpl:3, inv:0};
    mD = '{hf:7, hs:9, hb:5, hv:20, hbd:4, vs:3, vu:4, vl:9, vlo:5, vbd:2, ppc:5, cpl:2, inv:1};
    mE = '{hf:1, hs:1, hb:1, hv:6,  hbd:1, vs:1, vu:1, vl:3, vlo:1, vbd:0, ppc:1, cpl:4, inv:1};

    applyMode(mA);
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 hsync", int'(hsyncO), 1);
    chk("R1 vsync", int'(vsyncO), 1);
    chk("R1 border", int'(borderO), 0);
    chk("R1 active", int'(activeO), 0);
    chk("R1 pixX", int'(pixX), 0);
    chk("R1 lineY", int'(lineY), 0);
    chk("R1 charCol", int'(charCol), 0);

    pushFrame(mA, 0);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R8 capture clock: outputs stay idle
    chk("R8 idle hsync", int'(hsyncO), 1);
    chk("R8 idle vsync", int'(vsyncO), 1);
    chk("R8 idle border", int'(borderO), 0);
    chk("R8 idle active", int'(activeO), 0);
    @(posedge clk);
    #1 monOn = 1;

    while (q.size() > frameLen(mA) / 2) @(negedge clk);
    applyMode(mB);        // R4 inverted polarity, zero border (R5)
    pushFrame(mB, 1);

    while (q.size() > frameLen(mB) / 2) @(negedge clk);
    applyMode(mC);        // R7 column wrap
    pushFrame(mC, 2);

    while (q.size() > frameLen(mC) / 2) @(negedge clk);
    applyMode(mA);
    pushFrame(mA, 3);

    while (q.size() > frameLen(mA) / 2) @(negedge clk);
    applyMode(mD);        // R9 transient junk during frame 3
    repeat (10) @(negedge clk);
    applyMode(mE);
    pushFrame(mE, 4);

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    monOn = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule